// File: doc/BRIEF.md
# Multiplier-free PVQ dot-product accumulator

This block forms the raw integer dot product between an input vector and a weight vector whose integer entries have absolute values that add up to a fixed total Q. It contains no multiplier. Each weight of magnitude m costs m accumulator cycles. In each of those cycles the matching input element is added to the running sum, or subtracted from it when the weight is negative. The result is left unscaled, so a later normalisation stage can apply the quantiser's norm factor.

Weights arrive as run-length pairs. Each pair gives the count of zero weights that come before it and a signed weight value. The pair (0,0) closes the vector. The block rebuilds each weight's vector position from the runs and presents that position on `x_idx`. The surrounding logic returns the element on `x_data` in the same cycle, for example from a combinational register file. The first unit addition of a weight happens in the cycle its pair is accepted, so zero runs cost nothing. A vector takes exactly Q accumulation cycles, plus one cycle for the end marker.

The sequencer has four states:
- ST_IDLE waits for `start`.
- ST_FETCH accepts pairs.
- ST_REPEAT repeats the add or subtract for the remaining units of a weight.
- ST_FINISH raises `done` for one cycle.

The transitions are:
- ST_IDLE to ST_FETCH on `start`.
- ST_FETCH to ST_REPEAT on a pair with magnitude above one.
- ST_FETCH stays in ST_FETCH on any other non-end pair.
- ST_FETCH to ST_FINISH on the end marker.
- ST_REPEAT back to ST_FETCH after its last unit.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `pvq_dot_accum`

## Requirements
- R1: After reset, `acc` and `unit_count` are 0 and `done`, `busy` and `pair_ready` are low.
- R2: `start` in idle clears `acc`, `unit_count` and the position origin to 0. One cycle later `busy` and `pair_ready` are high.
- R3: A pair with a positive weight w adds x[j] into `acc` w times, one unit per cycle. The first unit is added at the clock edge that accepts the pair.
- R4: A pair with a negative weight w subtracts x[j] from `acc` |w| times, one unit per cycle. This holds down to the most negative weight value.
- R5: The position j of a weight is (the position after the previous non-zero weight, or 0 at the start of the vector) plus its zero run. `x_idx` shows j during every unit cycle of that weight.
- R6: A pair with weight 0 and a non-zero run moves the position forward by the run only. It takes one cycle and leaves `acc` and `unit_count` unchanged.
- R7: Accepting the end pair (zero run 0, weight 0) raises `done` for exactly one cycle on the next cycle. The block then returns to idle, and `acc` holds the result until the next `start`.
- R8: `unit_count` rises by one per unit cycle and equals Q (the sum of |w|) when `done` is high. `pair_ready` is low during the repeat cycles of a weight.
- R9: `start` while busy is ignored: `acc` and `unit_count` continue undisturbed.
- R10: `pair_valid` in idle is ignored: `pair_ready` stays low and `acc` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new dot product (acted on in idle only) |
| pair_valid | input | 1 | A run-length pair is presented |
| pair_ready | output | 1 | Block accepts the presented pair this cycle |
| pair_zrun | input | RUN_W | Count of zero weights before this weight |
| pair_wt | input | WT_W | Signed weight value, two's complement |
| x_idx | output | IDX_W | Position of the input element wanted this cycle |
| x_data | input | X_W | Signed input element at `x_idx`, same cycle |
| acc | output | ACC_W | Signed running dot product |
| unit_count | output | CNT_W | Number of unit accumulation cycles since `start` |
| done | output | 1 | One-cycle pulse after the end pair |
| busy | output | 1 | High from `start` until the block returns to idle |

## Verification
The bench builds the block with its default parameters: 6-bit weights, 8-bit inputs and positions, 8-bit zero runs and a 24-bit sum. With 6-bit weights the extreme magnitudes -32 and +31 can be reached in a few dozen cycles, so the longest repeat sequences and the magnitude of the most negative weight are exercised. Positions up to 255 let vectors mix long zero runs, weight-0 skip pairs and single-unit weights. With those values, a behavioural model that tracks the position and the sum can check every cycle.

// File: rtl/pvq_acc_pkg.sv
package pvq_acc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_REPEAT = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pvq_seq_fsm.sv
module pvq_seq_fsm
    import pvq_acc_pkg::*;
#(
    parameter int WT_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   pair_valid,
    input  logic                   pair_end,
    input  logic signed [WT_W-1:0] pair_wt,
    output logic                   pair_ready,
    output logic                   take_pair,
    output logic                   add_en,
    output logic                   add_neg,
    output logic                   clear,
    output logic                   in_repeat,
    output logic                   done,
    output logic                   busy
);
    localparam int SGN = WT_W - 1;

    seq_state_t      state, nxt;
    logic [WT_W-1:0] remain;
    logic            neg_q;
    logic [WT_W-1:0] pair_mag;

    // magnitude as unsigned WT_W bits; the most negative value maps correctly
    assign pair_mag = pair_wt[SGN] ? WT_W'(-pair_wt) : WT_W'(pair_wt);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH: begin
                if (pair_valid) begin
                    if (pair_end)                   nxt = ST_FINISH;
                    else if (pair_mag > WT_W'(1))   nxt = ST_REPEAT;
                end
            end
            ST_REPEAT: if (remain == WT_W'(1)) nxt = ST_FETCH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
            neg_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (take_pair) begin
                remain <= pair_mag - WT_W'(1);
                neg_q  <= pair_wt[SGN];
            end else if (state == ST_REPEAT) begin
                remain <= remain - WT_W'(1);
            end
        end
    end

    always_comb begin
        pair_ready = (state == ST_FETCH);
        take_pair  = (state == ST_FETCH) && pair_valid && !pair_end;
        in_repeat  = (state == ST_REPEAT);
        add_en     = (take_pair && (pair_mag != '0)) || in_repeat;
        add_neg    = in_repeat ? neg_q : pair_wt[SGN];
        clear      = (state == ST_IDLE) && start;
        done       = (state == ST_FINISH);
        busy       = (state != ST_IDLE);
    end

    assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && start) |=> pair_ready);
    assert_repeat_units_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEAT) |-> (remain != '0));
endmodule

// File: rtl/pvq_index_gen.sv
module pvq_index_gen #(
    parameter int IDX_W = 8,
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take_pair,
    input  logic             wt_nonzero,
    input  logic             in_repeat,
    input  logic [RUN_W-1:0] pair_zrun,
    output logic [IDX_W-1:0] x_idx
);
    logic [IDX_W-1:0] base_pos;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] target;

    assign target = base_pos + IDX_W'(pair_zrun);
    assign x_idx  = in_repeat ? cur_idx : target;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_pos <= '0;
            cur_idx  <= '0;
        end else if (clear) begin
            base_pos <= '0;
            cur_idx  <= '0;
        end else if (take_pair) begin
            cur_idx  <= target;
            base_pos <= target + (wt_nonzero ? IDX_W'(1) : IDX_W'(0));
        end
    end

    assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_repeat |=> (!in_repeat || $stable(x_idx)));
    assert_base_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pair && wt_nonzero) |=> (base_pos == $past(x_idx) + IDX_W'(1)));
endmodule

// File: rtl/pvq_accum_dp.sv
module pvq_accum_dp #(
    parameter int X_W   = 8,
    parameter int ACC_W = 24,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    add_en,
    input  logic                    add_neg,
    input  logic signed [X_W-1:0]   x_data,
    output logic signed [ACC_W-1:0] acc,
    output logic [CNT_W-1:0]        unit_count
);
    localparam int EXT = ACC_W - X_W;

    logic signed [ACC_W-1:0] x_ext;
    assign x_ext = {{EXT{x_data[X_W-1]}}, x_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc        <= '0;
            unit_count <= '0;
        end else if (clear) begin
            acc        <= '0;
            unit_count <= '0;
        end else if (add_en) begin
            acc        <= add_neg ? (acc - x_ext) : (acc + x_ext);
            unit_count <= unit_count + CNT_W'(1);
        end
    end

    assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !clear) |=> $stable(acc));
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |=> (unit_count == $past(unit_count) + CNT_W'(1)));
endmodule

// File: rtl/pvq_dot_accum.sv
module pvq_dot_accum #(
    parameter int IDX_W = 8,
    parameter int RUN_W = 8,
    parameter int WT_W  = 6,
    parameter int X_W   = 8,
    parameter int ACC_W = 24,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    pair_valid,
    output logic                    pair_ready,
    input  logic [RUN_W-1:0]        pair_zrun,
    input  logic signed [WT_W-1:0]  pair_wt,
    output logic [IDX_W-1:0]        x_idx,
    input  logic signed [X_W-1:0]   x_data,
    output logic signed [ACC_W-1:0] acc,
    output logic [CNT_W-1:0]        unit_count,
    output logic                    done,
    output logic                    busy
);
    logic pair_end, wt_nonzero;
    logic take_pair, add_en, add_neg, clear, in_repeat;

    assign wt_nonzero = (pair_wt != '0);
    assign pair_end   = (pair_zrun == '0) && !wt_nonzero;

    pvq_seq_fsm #(.WT_W(WT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .pair_valid(pair_valid),
        .pair_end(pair_end), .pair_wt(pair_wt), .pair_ready(pair_ready),
        .take_pair(take_pair), .add_en(add_en), .add_neg(add_neg),
        .clear(clear), .in_repeat(in_repeat), .done(done), .busy(busy)
    );

    pvq_index_gen #(.IDX_W(IDX_W), .RUN_W(RUN_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clear(clear), .take_pair(take_pair),
        .wt_nonzero(wt_nonzero), .in_repeat(in_repeat),
        .pair_zrun(pair_zrun), .x_idx(x_idx)
    );

    pvq_accum_dp #(.X_W(X_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .clear(clear), .add_en(add_en),
        .add_neg(add_neg), .x_data(x_data), .acc(acc), .unit_count(unit_count)
    );
endmodule

// File: tb/pvq_dot_accum_test.sv
module pvq_dot_accum_test;
    localparam int IDX_W = 8, RUN_W = 8, WT_W = 6, X_W = 8, ACC_W = 24, CNT_W = 16;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pair_valid = 1'b0;
    logic pair_ready, done, busy;
    logic [RUN_W-1:0] pair_zrun = '0;
    logic signed [WT_W-1:0] pair_wt = '0;
    logic [IDX_W-1:0] x_idx;
    logic signed [X_W-1:0] x_data;
    logic signed [ACC_W-1:0] acc;
    logic [CNT_W-1:0] unit_count;

    always #4 clk = ~clk;

    pvq_dot_accum uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pair_valid(pair_valid),
        .pair_ready(pair_ready), .pair_zrun(pair_zrun), .pair_wt(pair_wt),
        .x_idx(x_idx), .x_data(x_data), .acc(acc), .unit_count(unit_count),
        .done(done), .busy(busy)
    );

    function automatic int xval(input int i);
        return ((i * 37 + 11) % 251) - 125;
    endfunction

    assign x_data = X_W'(xval(int'(x_idx)));

    int total = 0, bad = 0;
    int exp_acc, exp_cnt, pos;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic check_sum(input string tag);
        chk($signed(acc) == exp_acc, {tag, " acc"}, int'($signed(acc)), exp_acc);
        chk(int'(unit_count) == exp_cnt, {tag, " unit_count"}, int'(unit_count), exp_cnt);
    endtask

    task automatic begin_vec();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_acc = 0; exp_cnt = 0; pos = 0;
        check_sum("R2 cleared");
        chk(busy && pair_ready, "R2 busy/ready", int'({busy, pair_ready}), 3);
    endtask

    task automatic send_pair(input int z, input int w, input bit poke_start);
        int idx, mag, sgn;
        string tag;
        idx = pos + z;
        mag = (w < 0) ? -w : w;
        sgn = (w < 0) ? -1 : 1;
        tag = (w < 0) ? "R4" : "R3";
        pair_zrun = RUN_W'(z); pair_wt = WT_W'(w); pair_valid = 1'b1;
        #1;
        chk(pair_ready, "R8 ready in fetch", int'(pair_ready), 1);
        chk(int'(x_idx) == idx, "R5 index", int'(x_idx), idx);
        @(negedge clk);
        pair_valid = 1'b0;
        if (w != 0) begin
            exp_acc += sgn * xval(idx); exp_cnt++; pos = idx + 1;
            check_sum(tag);
        end else begin
            pos = idx;
            check_sum("R6 skip pair");
        end
        for (int k = 1; k < mag; k++) begin
            start = poke_start;
            #1;
            chk(!pair_ready, "R8 ready low in repeat", int'(pair_ready), 0);
            chk(int'(x_idx) == idx, "R5 index held", int'(x_idx), idx);
            @(negedge clk);
            start = 1'b0;
            exp_acc += sgn * xval(idx); exp_cnt++;
            check_sum(poke_start ? "R9 start ignored" : tag);
        end
    endtask

    task automatic end_vec();
        int q;
        q = exp_cnt;
        pair_zrun = '0; pair_wt = '0; pair_valid = 1'b1;
        #1;
        chk(pair_ready, "R7 ready for end", int'(pair_ready), 1);
        @(negedge clk);
        pair_valid = 1'b0;
        chk(done, "R7 done high", int'(done), 1);
        check_sum("R7 result");
        chk(int'(unit_count) == q, "R8 count equals Q", int'(unit_count), q);
        @(negedge clk);
        chk(!done && !busy, "R7 done single, idle", int'({done, busy}), 0);
        check_sum("R7 held");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(acc == '0 && unit_count == '0, "R1 reset sum", int'(acc), 0);
        chk(!done && !busy && !pair_ready, "R1 reset flags",
            int'({done, busy, pair_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: pairs offered while idle
        pair_zrun = 8'd3; pair_wt = 6'sd5; pair_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(!pair_ready, "R10 no ready in idle", int'(pair_ready), 0);
            @(negedge clk);
            chk(acc == '0 && unit_count == '0 && !busy, "R10 sum untouched",
                int'(acc), 0);
        end
        pair_valid = 1'b0;

        begin_vec();                          // mixed signs
        send_pair(1, 3, 1'b0);
        send_pair(0, -2, 1'b0);
        send_pair(4, 1, 1'b0);
        end_vec();

        begin_vec();                          // extreme magnitudes, start while busy
        send_pair(2, -32, 1'b1);
        send_pair(0, 31, 1'b0);
        end_vec();

        begin_vec();                          // skip pairs
        send_pair(10, 0, 1'b0);
        send_pair(0, 1, 1'b0);
        send_pair(5, 0, 1'b0);
        send_pair(3, -1, 1'b0);
        end_vec();

        begin_vec();                          // empty vector
        end_vec();

        begin_vec();                          // longer pattern
        for (int i = 0; i < 8; i++)
            send_pair(i, (i % 2 == 1) ? -(i + 1) : (i + 2), 1'b0);
        end_vec();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule